// File: doc/BRIEF.md
# I/O Interrupt Redirection Controller

This block holds the programmable state of an I/O interrupt controller and turns device pin events into interrupt messages. Software reaches every register through two bus offsets. The first is an index register. The second is a data window that accesses whichever internal register the index selects. The internal registers are the controller identifier, a read-only version word, an arbitration word and a table of redirection entries. Each entry is 64 bits wide and is reached as a low half and a high half.

When a device raises a pin, the block reads that pin's entry. If the pin number is valid and the entry is not masked, the block rewrites the entry into the format of a processor's interrupt command register. Some fields are forced to fixed values and others are cleared. The block then presents the result to the message router as a 64-bit command word. The router also receives the controller's identifier as the source, and a one-cycle send strobe. Only one message is in flight at a time. A pin event offered while a message is waiting is held back by `raise_ready` until the router acknowledges.

Top module: `ioirc_top`

## Requirements
- R1: After reset, the registers hold these values: index 0, identifier equal to NUM_CORES (4), version 0x00170011, arbitration 0. Every entry low half is 0x00010000, which means masked, and every entry high half is 0. After reset `raise_ready` is 1 and `send_strobe` is 0.
- R2: Bus offset 0x00 reads and writes the index register, held as 8 bits. Bus offset 0x10 is the data window. The index value selects the target of the window as follows:
  - 0 selects the identifier (read/write, 8 bits).
  - 1 selects the version word.
  - 2 selects the arbitration word (read/write, 32 bits).
  - 0x10+2n selects the low half of entry n.
  - 0x11+2n selects the high half of entry n.
- R3: The version word is read-only. A window write while the index is 1 raises `bus_err` in that cycle and leaves the version at 0x00170011.
- R4: The table slot is computed as (index−0x10)>>1. A window access, read or write, with a slot above 0x3F (index 0x90 and up) raises `bus_err`. Such a read returns 0 and such a write changes nothing. Slots from NUM_ENTRIES up to 0x3F read 0 without error.
- R5: A low-half write changes only the bits set in the writable mask 0x0001AFFF. The other low bits keep their value. A high-half write replaces all 32 bits.
- R6: A pin event with a pin number above 24 (NUM_ENTRIES−1) raises `pin_reject` in that cycle and produces no send.
- R7: A pin event whose entry has bit 16 (mask) set produces no send.
- R8: The command word is the 64-bit entry (high half in bits 63:32) with these changes:
  - bit 13 cleared
  - bit 14 set to 1
  - bit 15 kept from the entry's trigger bit
  - bits 19:16 cleared
  - bits 55:20 cleared

  The destination (63:56) and bits 12:0 are copied unchanged.
- R9: `src_id` carries the identifier register value at the time the pin event was accepted.
- R10: An accepted event pulses `send_strobe` for exactly one cycle, in the cycle after acceptance. `raise_ready` stays 0, with `cmd_word` and `src_id` held, from that cycle until the cycle after `send_ack` is seen. A pin event offered while `raise_ready` is 0 is not taken, and is taken once `raise_ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 8 | Bus offset (0x00 index, 0x10 window) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_re` is high |
| bus_err | output | 1 | Access rejected (version write, slot out of range) |
| pin_valid | input | 1 | A device pin is raised |
| pin_num | input | 6 | Number of the raised pin |
| raise_ready | output | 1 | A pin event can be taken this cycle |
| pin_reject | output | 1 | Pin number out of range |
| send_ack | input | 1 | Router has accepted the pending message |
| send_strobe | output | 1 | One-cycle send request |
| cmd_word | output | 64 | Translated interrupt command word |
| src_id | output | 8 | Source identifier of the message |

## Verification
The case hardest to reach from the ports is a second pin event that arrives while a message is still waiting for the router. To reach it, the stimulus programs two distinct unmasked entries and raises the first pin. It then withholds `send_ack` while the second pin is held valid over several cycles. During those cycles the bench checks that neither the strobe nor the command word moves. Only after the acknowledge does the second event go out, carrying its own translated word. Each pin's expected command word is derived arithmetically from the values written into its entry, so a wrong translation bit or a stale snapshot shows up on the specific pin concerned.

// File: rtl/ioirc_pkg.sv
package ioirc_pkg;
   localparam int unsigned REG_W      = 32;
   localparam int unsigned MSG_W      = 64;
   localparam int unsigned IX_W       = 8;
   // internal register numbers reached through the data window
   localparam logic [IX_W-1:0] SEL_ID  = 8'h00;
   localparam logic [IX_W-1:0] SEL_VER = 8'h01;
   localparam logic [IX_W-1:0] SEL_ARB = 8'h02;
   localparam logic [IX_W-1:0] TBL_BASE = 8'h10;
   localparam logic [IX_W-1:0] MAX_SLOT = 8'h3F;
   // entry field positions
   localparam int unsigned MASK_BIT   = 16;
   localparam int unsigned TRIG_BIT   = 15;
   localparam int unsigned LVL_BIT    = 14;
   localparam int unsigned RSV_BIT    = 13;
   localparam logic [REG_W-1:0] LO_RESET = 32'h0001_0000;

   typedef logic [MSG_W-1:0] msg_t;

   function automatic msg_t entry_to_cmd(msg_t ent);
      msg_t c;
      c            = ent;
      c[RSV_BIT]   = 1'b0;
      c[LVL_BIT]   = 1'b1;
      c[TRIG_BIT]  = ent[TRIG_BIT];
      c[17:16]     = 2'b00;
      c[19:18]     = 2'b00;
      c[55:20]     = '0;
      return c;
   endfunction
endpackage

// File: rtl/ioirc_regfile.sv
module ioirc_regfile
   import ioirc_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned ID_W        = 8,
   parameter int unsigned NUM_CORES   = 4,
   parameter int unsigned NUM_ENTRIES = 25,
   parameter int unsigned PIN_W       = 6,
   parameter logic [31:0] VERSION     = 32'h0017_0011,
   parameter logic [31:0] LO_WR_MASK  = 32'h0001_AFFF,
   parameter int unsigned IDX_OFF     = 0,
   parameter int unsigned WIN_OFF     = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic              bus_re,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   output logic              bus_err,
   input  logic [PIN_W-1:0]  pin_sel,
   output msg_t              pin_entry,
   output logic [ID_W-1:0]   ctl_id
);
   localparam logic [ID_W-1:0] ID_RESET = ID_W'(NUM_CORES);

   logic [IX_W-1:0]  index_q;
   logic [ID_W-1:0]  id_q;
   logic [REG_W-1:0] arb_q;
   logic [REG_W-1:0] lo_q [NUM_ENTRIES];
   logic [REG_W-1:0] hi_q [NUM_ENTRIES];

   logic            is_idx, is_win, in_tbl, hi_half, bad_slot, wr_win;
   logic [IX_W-1:0] slot;

   assign is_idx   = (bus_addr == ADDR_W'(IDX_OFF));
   assign is_win   = (bus_addr == ADDR_W'(WIN_OFF));
   assign in_tbl   = (index_q >= TBL_BASE);
   assign slot     = (index_q - TBL_BASE) >> 1;
   assign hi_half  = index_q[0];
   assign bad_slot = in_tbl && (slot > MAX_SLOT);
   assign wr_win   = bus_we && is_win;

   assign bus_err = (bus_we || bus_re) && is_win &&
                    (bad_slot || (bus_we && (index_q == SEL_VER)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         index_q <= '0;
         id_q    <= ID_RESET;
         arb_q   <= '0;
      end else begin
         if (bus_we && is_idx)
            index_q <= bus_wdata[IX_W-1:0];
         if (wr_win && (index_q == SEL_ID))
            id_q <= bus_wdata[ID_W-1:0];
         if (wr_win && (index_q == SEL_ARB))
            arb_q <= bus_wdata;
      end
   end

   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
      logic hit;
      assign hit = in_tbl && (slot == IX_W'(e));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lo_q[e] <= LO_RESET;
            hi_q[e] <= '0;
         end else if (wr_win && hit) begin
            if (hi_half)
               hi_q[e] <= bus_wdata;
            else
               lo_q[e] <= (lo_q[e] & ~LO_WR_MASK) | (bus_wdata & LO_WR_MASK);
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_re && is_idx) begin
         bus_rdata = REG_W'(index_q);
      end else if (bus_re && is_win) begin
         if (index_q == SEL_ID)
            bus_rdata = REG_W'(id_q);
         else if (index_q == SEL_VER)
            bus_rdata = VERSION;
         else if (index_q == SEL_ARB)
            bus_rdata = arb_q;
         else begin
            for (int e = 0; e < NUM_ENTRIES; e++) begin
               if (in_tbl && (slot == IX_W'(e)))
                  bus_rdata = hi_half ? hi_q[e] : lo_q[e];
            end
         end
      end
   end

   always_comb begin
      pin_entry = '0;
      for (int e = 0; e < NUM_ENTRIES; e++) begin
         if (pin_sel == PIN_W'(e))
            pin_entry = {hi_q[e], lo_q[e]};
      end
   end

   assign ctl_id = id_q;
endmodule

// File: rtl/ioirc_pin_gate.sv
module ioirc_pin_gate
   import ioirc_pkg::*;
#(
   parameter int unsigned PIN_W       = 6,
   parameter int unsigned NUM_ENTRIES = 25
)(
   input  logic             pin_valid,
   input  logic [PIN_W-1:0] pin_num,
   input  logic             raise_ready,
   input  msg_t             pin_entry,
   output logic             pin_reject,
   output logic             load,
   output msg_t             cmd_next
);
   localparam logic [PIN_W-1:0] MAX_PIN = PIN_W'(NUM_ENTRIES - 1);

   logic take, out_of_range;

   assign take         = pin_valid && raise_ready;
   assign out_of_range = (pin_num > MAX_PIN);
   assign pin_reject   = take && out_of_range;
   assign load         = take && !out_of_range && !pin_entry[MASK_BIT];
   assign cmd_next     = entry_to_cmd(pin_entry);
endmodule

// File: rtl/ioirc_sender.sv
module ioirc_sender
   import ioirc_pkg::*;
#(
   parameter int unsigned ID_W = 8
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  msg_t            cmd_next,
   input  logic [ID_W-1:0] src_next,
   input  logic            send_ack,
   output logic            raise_ready,
   output logic            send_strobe,
   output msg_t            cmd_word,
   output logic [ID_W-1:0] src_id
);
   logic busy_q, strobe_q;
   msg_t cmd_q;
   logic [ID_W-1:0] src_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         strobe_q <= 1'b0;
         cmd_q    <= '0;
         src_q    <= '0;
      end else begin
         strobe_q <= load;
         if (load) begin
            busy_q <= 1'b1;
            cmd_q  <= cmd_next;
            src_q  <= src_next;
         end else if (busy_q && send_ack) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign raise_ready = !busy_q;
   assign send_strobe = strobe_q;
   assign cmd_word    = cmd_q;
   assign src_id      = src_q;
endmodule

// File: rtl/ioirc_top.sv
module ioirc_top
   import ioirc_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned ID_W        = 8,
   parameter int unsigned NUM_CORES   = 4,
   parameter int unsigned NUM_ENTRIES = 25,
   parameter int unsigned PIN_W       = 6,
   parameter logic [31:0] VERSION     = 32'h0017_0011,
   parameter logic [31:0] LO_WR_MASK  = 32'h0001_AFFF,
   parameter int unsigned IDX_OFF     = 0,
   parameter int unsigned WIN_OFF     = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic              bus_re,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              bus_err,
   input  logic              pin_valid,
   input  logic [PIN_W-1:0]  pin_num,
   output logic              raise_ready,
   output logic              pin_reject,
   input  logic              send_ack,
   output logic              send_strobe,
   output logic [63:0]       cmd_word,
   output logic [ID_W-1:0]   src_id
);
   if (NUM_ENTRIES < 1 || NUM_ENTRIES > 64) begin : g_bad_entries
      $error("NUM_ENTRIES must lie in 1..64");
   end
   if (NUM_ENTRIES > (1 << PIN_W)) begin : g_bad_pinw
      $error("PIN_W too narrow for NUM_ENTRIES");
   end
   if (ID_W < 1 || ID_W > 8 || NUM_CORES >= (1 << ID_W)) begin : g_bad_id
      $error("ID_W must be 1..8 and hold NUM_CORES");
   end
   if (IDX_OFF == WIN_OFF || IDX_OFF >= (1 << ADDR_W) || WIN_OFF >= (1 << ADDR_W)) begin : g_bad_off
      $error("bus offsets must differ and fit ADDR_W");
   end

   msg_t            pin_entry, cmd_next;
   logic [ID_W-1:0] ctl_id;
   logic            load;

   ioirc_regfile #(
      .ADDR_W(ADDR_W), .ID_W(ID_W), .NUM_CORES(NUM_CORES),
      .NUM_ENTRIES(NUM_ENTRIES), .PIN_W(PIN_W), .VERSION(VERSION),
      .LO_WR_MASK(LO_WR_MASK), .IDX_OFF(IDX_OFF), .WIN_OFF(WIN_OFF)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_err(bus_err), .pin_sel(pin_num), .pin_entry(pin_entry),
      .ctl_id(ctl_id)
   );

   ioirc_pin_gate #(.PIN_W(PIN_W), .NUM_ENTRIES(NUM_ENTRIES)) u_gate (
      .pin_valid(pin_valid), .pin_num(pin_num), .raise_ready(raise_ready),
      .pin_entry(pin_entry), .pin_reject(pin_reject), .load(load),
      .cmd_next(cmd_next)
   );

   ioirc_sender #(.ID_W(ID_W)) u_send (
      .clk(clk), .rst_n(rst_n), .load(load), .cmd_next(cmd_next),
      .src_next(ctl_id), .send_ack(send_ack), .raise_ready(raise_ready),
      .send_strobe(send_strobe), .cmd_word(cmd_word), .src_id(src_id)
   );
endmodule

// File: rtl/ioirc_checker.sv
module ioirc_checker #(
   parameter int unsigned PIN_W = 6,
   parameter int unsigned ID_W  = 8
)(
   input logic             clk,
   input logic             rst_n,
   input logic             pin_valid,
   input logic [PIN_W-1:0] pin_num,
   input logic             raise_ready,
   input logic             pin_reject,
   input logic             send_ack,
   input logic             send_strobe,
   input logic [63:0]      cmd_word,
   input logic [ID_W-1:0]  src_id
);
   assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      send_strobe |=> !send_strobe);

   assert_busy_at_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      send_strobe |-> !raise_ready);

   assert_strobe_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      send_strobe |-> $past(pin_valid && raise_ready));

   assert_hold_msg_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!raise_ready && !send_ack) |=> ($stable(cmd_word) && $stable(src_id) && !raise_ready));

   assert_cmd_format_R8: assert property (@(posedge clk) disable iff (!rst_n)
      send_strobe |-> (cmd_word[55:16] == 40'h0 && cmd_word[14] && !cmd_word[13]));

   assert_reject_no_send_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pin_reject |=> !send_strobe);

   assert_reject_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pin_reject |-> (pin_valid && pin_num > PIN_W'(24)));
endmodule

bind ioirc_top ioirc_checker #(.PIN_W(PIN_W), .ID_W(ID_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pin_valid(pin_valid), .pin_num(pin_num),
   .raise_ready(raise_ready), .pin_reject(pin_reject), .send_ack(send_ack),
   .send_strobe(send_strobe), .cmd_word(cmd_word), .src_id(src_id)
);

// File: tb/ioirc_top_test.sv
module ioirc_top_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] WMASK = 32'h0001_AFFF;
   localparam logic [63:0] KEEP  = 64'hFF00_0000_0000_9FFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0, bus_re = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_err;
   logic        pin_valid = 1'b0;
   logic [5:0]  pin_num = '0;
   logic        raise_ready, pin_reject;
   logic        send_ack = 1'b0;
   logic        send_strobe;
   logic [63:0] cmd_word;
   logic [7:0]  src_id;

   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ioirc_top uut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_err(bus_err), .pin_valid(pin_valid), .pin_num(pin_num),
      .raise_ready(raise_ready), .pin_reject(pin_reject), .send_ack(send_ack),
      .send_strobe(send_strobe), .cmd_word(cmd_word), .src_id(src_id)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive one bus write; returns err seen during the cycle
   task automatic bus_write(input logic [7:0] a, input logic [31:0] d, output logic err);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      #1 err = bus_err;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d, output logic err);
      @(negedge clk);
      bus_re = 1'b1; bus_addr = a;
      #1 begin d = bus_rdata; err = bus_err; end
      @(negedge clk);
      bus_re = 1'b0;
   endtask

   task automatic win_write(input logic [7:0] ix, input logic [31:0] d, output logic err);
      logic e0;
      bus_write(8'h00, {24'h0, ix}, e0);
      bus_write(8'h10, d, err);
   endtask

   task automatic win_read(input logic [7:0] ix, output logic [31:0] d, output logic err);
      logic e0;
      bus_write(8'h00, {24'h0, ix}, e0);
      bus_read(8'h10, d, err);
   endtask

   function automatic logic [31:0] lo_pat(int i);
      return (32'hA5A5_5A5A ^ (i * 32'h0101_3777)) & ~32'h0001_0000;
   endfunction
   function automatic logic [31:0] hi_pat(int i);
      return {8'(8'h40 + i), 24'h5A5A5A ^ 24'(i * 24'h010203)};
   endfunction
   function automatic logic [63:0] exp_cmd(int i);
      logic [63:0] ent;
      ent = {hi_pat(i), lo_pat(i) & WMASK};
      return (ent & KEEP) | 64'h4000;
   endfunction

   // raise a pin while idle; sample strobe and message after the edge
   task automatic raise_pin(input int p, output logic stb, output logic [63:0] cw, output logic [7:0] sid);
      @(negedge clk);
      pin_valid = 1'b1; pin_num = 6'(p);
      @(negedge clk);
      pin_valid = 1'b0;
      stb = send_strobe; cw = cmd_word; sid = src_id;
   endtask

   task automatic ack_send();
      @(negedge clk);
      send_ack = 1'b1;
      @(negedge clk);
      send_ack = 1'b0;
   endtask

   initial begin
      logic [31:0] d;
      logic        e, stb;
      logic [63:0] cw;
      logic [7:0]  sid;
      bit          ok;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check(raise_ready === 1'b1 && send_strobe === 1'b0, "R1 ready/strobe",
            {62'h0, raise_ready, send_strobe}, 64'h2);
      bus_read(8'h00, d, e);
      check(d === 32'h0, "R1 index reset", 64'(d), 64'h0);
      win_read(8'h00, d, e);
      check(d === 32'h4, "R1 id reset", 64'(d), 64'h4);
      win_read(8'h01, d, e);
      check(d === 32'h0017_0011 && !e, "R1 version reset", 64'(d), 64'h0017_0011);
      win_read(8'h02, d, e);
      check(d === 32'h0, "R1 arb reset", 64'(d), 64'h0);
      ok = 1'b1;
      for (int i = 0; i < 25; i++) begin
         win_read(8'(8'h10 + 2*i), d, e);
         if (d !== 32'h0001_0000) ok = 1'b0;
         win_read(8'(8'h11 + 2*i), d, e);
         if (d !== 32'h0) ok = 1'b0;
      end
      check(ok, "R1 table reset masked", 64'(ok), 64'h1);

      // R2 read/write id and arbitration
      win_write(8'h02, 32'hDEAD_BEEF, e);
      win_read(8'h02, d, e);
      check(d === 32'hDEAD_BEEF, "R2 arb rw", 64'(d), 64'hDEAD_BEEF);
      bus_read(8'h00, d, e);
      check(d === 32'h02, "R2 index readback", 64'(d), 64'h2);

      // R3 version is read-only
      win_write(8'h01, 32'h1234_5678, e);
      check(e === 1'b1, "R3 version write err", 64'(e), 64'h1);
      win_read(8'h01, d, e);
      check(d === 32'h0017_0011, "R3 version unchanged", 64'(d), 64'h0017_0011);

      // R5 mask on low half, replacement on high half
      win_write(8'h10, 32'hFFFF_FFFF, e);
      win_read(8'h10, d, e);
      check(d === WMASK, "R5 low masked write", 64'(d), 64'(WMASK));
      win_write(8'h10, 32'h0000_0000, e);
      win_read(8'h10, d, e);
      check(d === 32'h0, "R5 low clear", 64'(d), 64'h0);
      ok = 1'b1;
      for (int i = 0; i < 25; i++) begin
         win_write(8'(8'h10 + 2*i), lo_pat(i), e);
         win_write(8'(8'h11 + 2*i), hi_pat(i), e);
      end
      for (int i = 0; i < 25; i++) begin
         win_read(8'(8'h10 + 2*i), d, e);
         if (d !== (lo_pat(i) & WMASK)) begin
            ok = 1'b0;
            check(1'b0, "R5 low readback", 64'(d), 64'(lo_pat(i) & WMASK));
         end
         win_read(8'(8'h11 + 2*i), d, e);
         if (d !== hi_pat(i)) begin
            ok = 1'b0;
            check(1'b0, "R5 high readback", 64'(d), 64'(hi_pat(i)));
         end
      end
      check(ok, "R5 table sweep", 64'(ok), 64'h1);

      // R4 slot range
      win_read(8'(8'h10 + 2*25), d, e);
      check(d === 32'h0 && e === 1'b0, "R4 unbacked slot reads zero", {31'h0, e, d}, 64'h0);
      win_read(8'h8F, d, e);
      check(d === 32'h0 && e === 1'b0, "R4 slot 0x3F no err", {31'h0, e, d}, 64'h0);
      win_read(8'h90, d, e);
      check(d === 32'h0 && e === 1'b1, "R4 slot 0x40 read err", {31'h0, e, d}, 64'h1_0000_0000);
      win_write(8'hFF, 32'hFFFF_FFFF, e);
      check(e === 1'b1, "R4 slot write err", 64'(e), 64'h1);
      win_read(8'h10, d, e);
      check(d === (lo_pat(0) & WMASK), "R4 rejected write no effect", 64'(d), 64'(lo_pat(0) & WMASK));

      // R8 R9 every pin translated, identifier as source
      for (int p = 0; p < 25; p++) begin
         raise_pin(p, stb, cw, sid);
         check(stb === 1'b1 && cw === exp_cmd(p) && sid === 8'h4, $sformatf("R8 R9 pin %0d", p),
               cw, exp_cmd(p));
         ack_send();
      end

      // R9 changed identifier is used
      win_write(8'h00, 32'h0000_0009, e);
      raise_pin(3, stb, cw, sid);
      check(sid === 8'h9, "R9 new id as source", 64'(sid), 64'h9);
      ack_send();

      // R6 out-of-range pins
      ok = 1'b1;
      for (int p = 25; p < 64; p++) begin
         @(negedge clk);
         pin_valid = 1'b1; pin_num = 6'(p);
         #1 if (pin_reject !== 1'b1) ok = 1'b0;
         @(negedge clk);
         pin_valid = 1'b0;
         if (send_strobe !== 1'b0 || raise_ready !== 1'b1) ok = 1'b0;
      end
      check(ok, "R6 pins above 24 rejected", 64'(ok), 64'h1);

      // R7 masked entry
      win_write(8'h10 + 8'd10, lo_pat(5) | 32'h0001_0000, e);
      raise_pin(5, stb, cw, sid);
      check(stb === 1'b0 && raise_ready === 1'b1, "R7 masked pin no send",
            {62'h0, stb, raise_ready}, 64'h1);

      // R10 hold while pending
      raise_pin(7, stb, cw, sid);
      check(stb === 1'b1, "R10 strobe after accept", 64'(stb), 64'h1);
      @(negedge clk);
      check(send_strobe === 1'b0 && raise_ready === 1'b0, "R10 single pulse busy",
            {62'h0, send_strobe, raise_ready}, 64'h0);
      pin_valid = 1'b1; pin_num = 6'd8;
      repeat (3) @(negedge clk);
      check(send_strobe === 1'b0 && cmd_word === exp_cmd(7), "R10 held while pending",
            cmd_word, exp_cmd(7));
      send_ack = 1'b1;
      @(negedge clk);
      send_ack = 1'b0;
      check(raise_ready === 1'b1 && send_strobe === 1'b0, "R10 ready after ack",
            {62'h0, raise_ready, send_strobe}, 64'h2);
      @(negedge clk);
      pin_valid = 1'b0;
      check(send_strobe === 1'b1 && cmd_word === exp_cmd(8), "R10 held pin sent",
            cmd_word, exp_cmd(8));
      ack_send();

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule